// File: doc/BRIEF.md
# Shadowed Video Memory Cycle Stretcher

This block sits between a CPU bus and two memory systems: a fast RAM that answers at the CPU rate, and a slow video RAM shared with the display scan-out. The slow RAM runs in fixed slots, and video and CPU take turns: one slot goes to the video reader, the next to the CPU, and so on. For every CPU bus cycle the block decodes the bank and offset of the address and the direction. It then decides whether the cycle can finish at the fast rate or must be held with a wait signal until a CPU-owned slow slot comes round.

Two kinds of cycle use the slow RAM. The first is any access whose bank is one of the two slow banks. The second, when shadowing is turned on, is a write into one of the configured video windows of the two low fast banks. Such a write lands in fast RAM at once and is also copied to the slow bank with the same low bank bit, and the CPU waits for that copy. All other cycles run unstalled, including every read of the fast banks. A 16-bit access is split into two byte accesses. Each byte gets its own CPU slot, so the second byte completes one full slot pair after the first.

Time is counted in fast ticks, which arrive on a clock-enable input. A slow slot lasts a parameterised number of ticks.

Top module: `vidmem_stretch`

## Requirements
- R1: A clock edge with `rst` high clears `cpu_wait`, `fast_we`, `slow_we` and `slow_re`. It also restarts the slot pattern so that the first tick after reset is tick 0 of a video-owned slot.
- R2: Tick t (counted from 0 after reset) lies in slot t / SLOT_TICKS, and even-numbered slots belong to video and odd-numbered slots to the CPU. Any access whose bank has upper seven bits equal to those of SLOW_BANK (default 0xE0, that is banks E0/E1) is stretched. Its slow strobe (`slow_we` for writes, `slow_re` for reads, never both at once) covers exactly the SLOT_TICKS ticks of the next CPU slot that begins after the starting tick, and never a tick of a video slot.
- R3: A read of a fast bank (upper seven bank bits equal to those of FAST_BANK, default banks 00/01) never raises `cpu_wait` and never raises a slow strobe, even inside an enabled video window with shadowing on.
- R4: A write outside every enabled window, or to any bank that is neither fast nor slow, completes unstalled. It gives one single-clock `fast_we` pulse in the clock after its starting tick and no slow strobe.
- R5: With `shadow_en` high, a write to a fast bank at an offset inside an enabled window (inclusive base and limit) pulses `fast_we` once. It also writes the slow bank {SLOW_BANK[7:1], bank[0]} at the same offset, and it is stretched exactly as a direct slow-bank write.
- R6: With `shadow_en` low, fast-bank writes inside video windows complete unstalled with a `fast_we` pulse and no slow strobe.
- R7: Bit i of `range_en` enables window i. By default window 0 covers offsets 0x0400 to 0x0BFF and window 1 covers 0x2000 to 0x9FFF. A write into a disabled window behaves as a write outside all windows.
- R8: With `cpu_wide` high, a stretched access performs two byte transfers. The first is at the given offset in the first CPU slot reached, and the second is at offset+1 in the next CPU slot. `cpu_wait` stays high through both.
- R9: A `cyc_start` presented while `cpu_wait` is high is ignored: it causes no `fast_we` pulse and changes neither the address, nor the strobes, nor the stall length of the access in progress.
- R10: `cpu_wait` rises in the clock after the tick on which a stretched cycle starts. It falls only on a tick edge that ends a CPU slot, so a stall lasts G + SLOT_TICKS − t0 ticks for a byte access (G + 3·SLOT_TICKS − t0 for a wide one), where t0 is the start tick and G is the first tick at or after t0 that ends a video slot.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Fast-rate clock enable; one pulse per CPU tick |
| cyc_start | input | 1 | CPU bus cycle begins on this tick |
| cpu_addr | input | 24 | Bank (upper 8 bits) and offset (lower 16 bits) |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_wide | input | 1 | 16-bit access, split into two bytes |
| shadow_en | input | 1 | Global shadow enable |
| range_en | input | 2 | Per-window shadow enables |
| cpu_wait | output | 1 | Stretch request to the CPU |
| fast_we | output | 1 | Single-clock write strobe to fast RAM |
| slow_we | output | 1 | Slow RAM write strobe, held for one CPU slot |
| slow_re | output | 1 | Slow RAM read strobe, held for one CPU slot |
| slow_addr | output | 24 | Slow RAM bank and offset of the current byte |

## Verification
The hardest situations to reach are the two ends of the phase relation between a cycle's start tick and the slot pattern. One is a start on the very tick that ends a video slot, which gives the shortest stall. The other is a start on the first tick of a CPU slot, which gives the longest stall because that slot cannot be used. The bench keeps its own tick count from reset, so it can hold a request back until the count modulo two slots reaches the residue it wants, and it computes the expected stall from that count. A wide shadowed write across a window limit, a request injected in the middle of a stall, and a reset in the middle of a stall are driven as directed cases.

// File: rtl/vms_pkg.sv
package vms_pkg;

   // Class of a decoded CPU access
   typedef enum logic [1:0] {
      ACC_FAST   = 2'd0,   // fast RAM only, never stretched
      ACC_SLOW   = 2'd1,   // direct slow-bank access
      ACC_MIRROR = 2'd2    // shadowed write: fast RAM plus slow copy
   } acc_kind_e;

   // Sequencer states
   typedef enum logic [1:0] {
      SQ_IDLE   = 2'd0,
      SQ_PEND   = 2'd1,    // waiting for the next CPU-owned slot
      SQ_ACTIVE = 2'd2     // slow strobe held through a CPU slot
   } seq_state_e;

endpackage

// File: rtl/vms_slot_timer.sv
module vms_slot_timer #(
   parameter int unsigned SLOT_TICKS = 3
) (
   input  logic clk,
   input  logic rst,
   input  logic tick,
   output logic cpu_owned,
   output logic grant_tick,
   output logic cpu_end
);

   localparam bit IS_POW2 = ((SLOT_TICKS & (SLOT_TICKS - 1)) == 0);

   initial begin
      assert (SLOT_TICKS >= 2)
         else $error("vms_slot_timer: SLOT_TICKS must be at least 2");
   end

   logic last;

   generate
      if (IS_POW2) begin : g_pow2
         // One free-running counter; its top bit names the owner
         localparam int unsigned CW = $clog2(SLOT_TICKS) + 1;
         logic [CW-1:0] cnt;
         always_ff @(posedge clk) begin
            if (rst)       cnt <= '0;
            else if (tick) cnt <= cnt + CW'(1);
         end
         assign cpu_owned = cnt[CW-1];
         assign last      = &cnt[CW-2:0];
      end else begin : g_mod
         // Position counter with explicit wrap plus an owner toggle
         localparam int unsigned PW = $clog2(SLOT_TICKS);
         logic [PW-1:0] pos;
         logic          own;
         always_ff @(posedge clk) begin
            if (rst) begin
               pos <= '0;
               own <= 1'b0;
            end else if (tick) begin
               if (pos == PW'(SLOT_TICKS - 1)) begin
                  pos <= '0;
                  own <= ~own;
               end else begin
                  pos <= pos + PW'(1);
               end
            end
         end
         assign cpu_owned = own;
         assign last      = (pos == PW'(SLOT_TICKS - 1));
      end
   endgenerate

   assign grant_tick = tick & last & ~cpu_owned;
   assign cpu_end    = tick & last &  cpu_owned;

endmodule

// File: rtl/vms_range_match.sv
module vms_range_match #(
   parameter int unsigned                   OFF_W      = 16,
   parameter int unsigned                   NUM_RANGES = 2,
   parameter logic [NUM_RANGES*OFF_W-1:0]   RANGE_BASE = {16'h2000, 16'h0400},
   parameter logic [NUM_RANGES*OFF_W-1:0]   RANGE_LIM  = {16'h9FFF, 16'h0BFF}
) (
   input  logic [OFF_W-1:0]      off,
   input  logic [NUM_RANGES-1:0] range_en,
   output logic                  hit
);

   logic [NUM_RANGES-1:0] hit_vec;

   generate
      for (genvar i = 0; i < NUM_RANGES; i++) begin : g_rng
         localparam logic [OFF_W-1:0] LO = RANGE_BASE[i*OFF_W +: OFF_W];
         localparam logic [OFF_W-1:0] HI = RANGE_LIM[i*OFF_W +: OFF_W];
         logic ge_lo, le_hi;

         initial begin
            assert (LO <= HI)
               else $error("vms_range_match: window %0d base above limit", i);
         end

         if (LO == '0) begin : g_lo_open
            assign ge_lo = 1'b1;
         end else begin : g_lo_cmp
            assign ge_lo = (off >= LO);
         end

         if (HI == '1) begin : g_hi_open
            assign le_hi = 1'b1;
         end else begin : g_hi_cmp
            assign le_hi = (off <= HI);
         end

         assign hit_vec[i] = range_en[i] & ge_lo & le_hi;
      end
   endgenerate

   assign hit = |hit_vec;

endmodule

// File: rtl/vms_addr_class.sv
module vms_addr_class
   import vms_pkg::*;
#(
   parameter int unsigned                   BANK_W     = 8,
   parameter int unsigned                   OFF_W      = 16,
   parameter int unsigned                   NUM_RANGES = 2,
   parameter logic [NUM_RANGES*OFF_W-1:0]   RANGE_BASE = {16'h2000, 16'h0400},
   parameter logic [NUM_RANGES*OFF_W-1:0]   RANGE_LIM  = {16'h9FFF, 16'h0BFF},
   parameter logic [BANK_W-1:0]             FAST_BANK  = 8'h00,
   parameter logic [BANK_W-1:0]             SLOW_BANK  = 8'hE0
) (
   input  logic [BANK_W+OFF_W-1:0] addr,
   input  logic                    we,
   input  logic                    shadow_en,
   input  logic [NUM_RANGES-1:0]   range_en,
   output acc_kind_e               kind,
   output logic [BANK_W-1:0]       slow_bank
);

   logic [BANK_W-1:0] bank;
   logic [OFF_W-1:0]  off;
   logic              in_slow, in_fast, vid_hit;

   assign bank = addr[BANK_W+OFF_W-1:OFF_W];
   assign off  = addr[OFF_W-1:0];

   // Bank pairs differ only in bit 0
   assign in_slow = (bank[BANK_W-1:1] == SLOW_BANK[BANK_W-1:1]);
   assign in_fast = (bank[BANK_W-1:1] == FAST_BANK[BANK_W-1:1]);

   vms_range_match #(
      .OFF_W      (OFF_W),
      .NUM_RANGES (NUM_RANGES),
      .RANGE_BASE (RANGE_BASE),
      .RANGE_LIM  (RANGE_LIM)
   ) u_match (
      .off      (off),
      .range_en (range_en),
      .hit      (vid_hit)
   );

   always_comb begin
      if (in_slow)
         kind = ACC_SLOW;
      else if (in_fast && we && shadow_en && vid_hit)
         kind = ACC_MIRROR;
      else
         kind = ACC_FAST;
   end

   // Same target for a direct slow access and for a mirror copy
   assign slow_bank = {SLOW_BANK[BANK_W-1:1], bank[0]};

endmodule

// File: rtl/vms_sequencer.sv
module vms_sequencer
   import vms_pkg::*;
#(
   parameter int unsigned BANK_W = 8,
   parameter int unsigned OFF_W  = 16
) (
   input  logic                    clk,
   input  logic                    rst,
   input  logic                    tick,
   input  logic                    cyc_start,
   input  logic                    we,
   input  logic                    wide,
   input  acc_kind_e               kind,
   input  logic [BANK_W-1:0]       slow_bank,
   input  logic [OFF_W-1:0]        off,
   input  logic                    grant_tick,
   input  logic                    cpu_end,
   output logic                    cpu_wait,
   output logic                    fast_we,
   output logic                    slow_we,
   output logic                    slow_re,
   output logic [BANK_W+OFF_W-1:0] slow_addr
);

   seq_state_e state;
   logic       second;
   logic       lat_we;
   logic       accept;

   // New cycles are only taken while nothing is in flight
   assign accept = tick & cyc_start & (state == SQ_IDLE);

   always_ff @(posedge clk) begin
      if (rst) begin
         state     <= SQ_IDLE;
         second    <= 1'b0;
         lat_we    <= 1'b0;
         cpu_wait  <= 1'b0;
         fast_we   <= 1'b0;
         slow_we   <= 1'b0;
         slow_re   <= 1'b0;
         slow_addr <= '0;
      end else begin
         fast_we <= accept & we & (kind != ACC_SLOW);

         unique case (state)
            SQ_IDLE: begin
               if (accept && kind != ACC_FAST) begin
                  cpu_wait  <= 1'b1;
                  lat_we    <= we;
                  second    <= wide;
                  slow_addr <= {slow_bank, off};
                  if (grant_tick) begin
                     state   <= SQ_ACTIVE;
                     slow_we <= we;
                     slow_re <= ~we;
                  end else begin
                     state   <= SQ_PEND;
                  end
               end
            end

            SQ_PEND: begin
               if (grant_tick) begin
                  state   <= SQ_ACTIVE;
                  slow_we <= lat_we;
                  slow_re <= ~lat_we;
               end
            end

            SQ_ACTIVE: begin
               if (cpu_end) begin
                  slow_we <= 1'b0;
                  slow_re <= 1'b0;
                  if (second) begin
                     second                 <= 1'b0;
                     slow_addr[OFF_W-1:0]   <= slow_addr[OFF_W-1:0] + OFF_W'(1);
                     state                  <= SQ_PEND;
                  end else begin
                     cpu_wait <= 1'b0;
                     state    <= SQ_IDLE;
                  end
               end
            end

            default: state <= SQ_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/vidmem_stretch.sv
module vidmem_stretch
   import vms_pkg::*;
#(
   parameter int unsigned                   BANK_W     = 8,
   parameter int unsigned                   OFF_W      = 16,
   parameter int unsigned                   SLOT_TICKS = 3,
   parameter int unsigned                   NUM_RANGES = 2,
   parameter logic [NUM_RANGES*OFF_W-1:0]   RANGE_BASE = {16'h2000, 16'h0400},
   parameter logic [NUM_RANGES*OFF_W-1:0]   RANGE_LIM  = {16'h9FFF, 16'h0BFF},
   parameter logic [BANK_W-1:0]             FAST_BANK  = 8'h00,
   parameter logic [BANK_W-1:0]             SLOW_BANK  = 8'hE0
) (
   input  logic                    clk,
   input  logic                    rst,
   input  logic                    tick,
   input  logic                    cyc_start,
   input  logic [BANK_W+OFF_W-1:0] cpu_addr,
   input  logic                    cpu_we,
   input  logic                    cpu_wide,
   input  logic                    shadow_en,
   input  logic [NUM_RANGES-1:0]   range_en,
   output logic                    cpu_wait,
   output logic                    fast_we,
   output logic                    slow_we,
   output logic                    slow_re,
   output logic [BANK_W+OFF_W-1:0] slow_addr
);

   initial begin
      assert (BANK_W >= 2)
         else $error("vidmem_stretch: BANK_W must be at least 2");
      assert (NUM_RANGES >= 1)
         else $error("vidmem_stretch: need at least one video window");
      assert (FAST_BANK[BANK_W-1:1] != SLOW_BANK[BANK_W-1:1])
         else $error("vidmem_stretch: fast and slow bank pairs overlap");
   end

   acc_kind_e         kind;
   logic [BANK_W-1:0] slow_bank;
   logic              cpu_owned, grant_tick, cpu_end;

   vms_slot_timer #(
      .SLOT_TICKS (SLOT_TICKS)
   ) u_timer (
      .clk        (clk),
      .rst        (rst),
      .tick       (tick),
      .cpu_owned  (cpu_owned),
      .grant_tick (grant_tick),
      .cpu_end    (cpu_end)
   );

   vms_addr_class #(
      .BANK_W     (BANK_W),
      .OFF_W      (OFF_W),
      .NUM_RANGES (NUM_RANGES),
      .RANGE_BASE (RANGE_BASE),
      .RANGE_LIM  (RANGE_LIM),
      .FAST_BANK  (FAST_BANK),
      .SLOW_BANK  (SLOW_BANK)
   ) u_class (
      .addr      (cpu_addr),
      .we        (cpu_we),
      .shadow_en (shadow_en),
      .range_en  (range_en),
      .kind      (kind),
      .slow_bank (slow_bank)
   );

   vms_sequencer #(
      .BANK_W (BANK_W),
      .OFF_W  (OFF_W)
   ) u_seq (
      .clk        (clk),
      .rst        (rst),
      .tick       (tick),
      .cyc_start  (cyc_start),
      .we         (cpu_we),
      .wide       (cpu_wide),
      .kind       (kind),
      .slow_bank  (slow_bank),
      .off        (cpu_addr[OFF_W-1:0]),
      .grant_tick (grant_tick),
      .cpu_end    (cpu_end),
      .cpu_wait   (cpu_wait),
      .fast_we    (fast_we),
      .slow_we    (slow_we),
      .slow_re    (slow_re),
      .slow_addr  (slow_addr)
   );

endmodule

// File: rtl/vms_stretch_chk.sv
module vms_stretch_chk #(
   parameter int unsigned       BANK_W    = 8,
   parameter logic [BANK_W-1:0] FAST_BANK = 8'h00,
   parameter logic [BANK_W-1:0] SLOW_BANK = 8'hE0
) (
   input logic              clk,
   input logic              rst,
   input logic              tick,
   input logic              cyc_start,
   input logic [BANK_W-2:0] bank_hi,
   input logic              we,
   input logic              shadow_en,
   input logic              cpu_wait,
   input logic              fast_we,
   input logic              slow_we,
   input logic              slow_re,
   input logic              cpu_owned
);

   logic taken, to_slow, to_fast;
   assign taken   = tick & cyc_start & ~cpu_wait;
   assign to_slow = (bank_hi == SLOW_BANK[BANK_W-1:1]);
   assign to_fast = (bank_hi == FAST_BANK[BANK_W-1:1]);

   AST_RESET_QUIET: assert property (@(posedge clk)
      rst |=> (!cpu_wait && !fast_we && !slow_we && !slow_re)); // R1

   AST_STROBE_CPU_SLOT: assert property (@(posedge clk) disable iff (rst)
      (slow_we || slow_re) |-> cpu_owned); // R2

   AST_STROBE_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
      !(slow_we && slow_re)); // R2

   AST_SLOW_STALLS: assert property (@(posedge clk) disable iff (rst)
      (taken && to_slow) |=> cpu_wait); // R2

   AST_FAST_READ_FREE: assert property (@(posedge clk) disable iff (rst)
      (taken && to_fast && !we) |=> !cpu_wait); // R3

   AST_UNSHADOWED_FREE: assert property (@(posedge clk) disable iff (rst)
      (taken && !to_slow && !shadow_en) |=> !cpu_wait); // R6

   AST_BUSY_NO_FAST: assert property (@(posedge clk) disable iff (rst)
      (cpu_wait && cyc_start) |=> !fast_we); // R9

   AST_STROBE_UNDER_WAIT: assert property (@(posedge clk) disable iff (rst)
      (slow_we || slow_re) |-> cpu_wait); // R10

   AST_WAIT_ON_TICK: assert property (@(posedge clk) disable iff (rst)
      !tick |=> $stable(cpu_wait)); // R10

   AST_RELEASE_SLOT_END: assert property (@(posedge clk) disable iff (rst)
      ($fell(cpu_wait) && !$past(rst)) |-> ($past(cpu_owned) && !cpu_owned)); // R10

endmodule

bind vidmem_stretch vms_stretch_chk #(
   .BANK_W    (BANK_W),
   .FAST_BANK (FAST_BANK),
   .SLOW_BANK (SLOW_BANK)
) u_chk (
   .clk       (clk),
   .rst       (rst),
   .tick      (tick),
   .cyc_start (cyc_start),
   .bank_hi   (cpu_addr[BANK_W+OFF_W-1:OFF_W+1]),
   .we        (cpu_we),
   .shadow_en (shadow_en),
   .cpu_wait  (cpu_wait),
   .fast_we   (fast_we),
   .slow_we   (slow_we),
   .slow_re   (slow_re),
   .cpu_owned (cpu_owned)
);

// File: tb/tb_vidmem_stretch.sv
module tb_vidmem_stretch;

   localparam int CLK_PERIOD = 10;
   localparam int S          = 3;

   // cls: 0 fast only, 1 direct slow, 2 shadow mirror
   typedef struct packed {
      logic [23:0] addr;
      logic        we;
      logic        wide;
      logic        shadow;
      logic [1:0]  ren;
      logic [1:0]  cls;
      logic [2:0]  gap;
      logic [3:0]  req;
   } vec_t;

   localparam int NV = 15;
   localparam vec_t VECS [NV] = '{
      '{24'hE11234, 1'b0, 1'b0, 1'b0, 2'b00, 2'd1, 3'd0, 4'd2},  // R2 slow read
      '{24'hE00500, 1'b1, 1'b0, 1'b0, 2'b00, 2'd1, 3'd1, 4'd2},  // R2 slow write
      '{24'h000400, 1'b1, 1'b0, 1'b1, 2'b11, 2'd2, 3'd2, 4'd5},  // R5 window base
      '{24'h019FFF, 1'b1, 1'b0, 1'b1, 2'b11, 2'd2, 3'd3, 4'd5},  // R5 window limit
      '{24'h01A000, 1'b1, 1'b0, 1'b1, 2'b11, 2'd0, 3'd1, 4'd4},  // R4 past limit
      '{24'h0003FF, 1'b1, 1'b0, 1'b1, 2'b11, 2'd0, 3'd4, 4'd4},  // R4 below base
      '{24'h000800, 1'b0, 1'b0, 1'b1, 2'b11, 2'd0, 3'd2, 4'd3},  // R3 shadowed read
      '{24'h012000, 1'b1, 1'b0, 1'b0, 2'b11, 2'd0, 3'd5, 4'd6},  // R6 shadow off
      '{24'h000400, 1'b1, 1'b0, 1'b1, 2'b10, 2'd0, 3'd0, 4'd7},  // R7 window off
      '{24'h013000, 1'b1, 1'b0, 1'b1, 2'b10, 2'd2, 3'd3, 4'd7},  // R7 window on
      '{24'hE12000, 1'b1, 1'b1, 1'b0, 2'b00, 2'd1, 3'd1, 4'd8},  // R8 wide slow write
      '{24'h000BFF, 1'b1, 1'b1, 1'b1, 2'b01, 2'd2, 3'd2, 4'd8},  // R8 wide mirror
      '{24'h120400, 1'b1, 1'b0, 1'b1, 2'b11, 2'd0, 3'd0, 4'd4},  // R4 other bank
      '{24'hE00000, 1'b0, 1'b1, 1'b0, 2'b00, 2'd1, 3'd5, 4'd8},  // R8 wide slow read
      '{24'h010500, 1'b0, 1'b1, 1'b1, 2'b11, 2'd0, 3'd3, 4'd3}   // R3 wide fast read
   };

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        tick_r;
   logic        tick;
   logic        cyc_start = 1'b0;
   logic [23:0] cpu_addr = '0;
   logic        cpu_we = 1'b0, cpu_wide = 1'b0, shadow_en = 1'b0;
   logic [1:0]  range_en = '0;
   logic        cpu_wait, fast_we, slow_we, slow_re;
   logic [23:0] slow_addr;

   int n_run  = 0;
   int n_fail = 0;
   int tno;

   always #(CLK_PERIOD/2) clk = ~clk;

   // Tick on every other clock; tno is the index of the tick now presented
   always @(posedge clk) begin
      if (rst) begin
         tick_r <= 1'b0;
         tno    <= 0;
      end else begin
         tick_r <= ~tick_r;
         if (tick_r) tno <= tno + 1;
      end
   end
   assign tick = tick_r;

   vidmem_stretch #(.SLOT_TICKS(S)) dut (
      .clk       (clk),
      .rst       (rst),
      .tick      (tick),
      .cyc_start (cyc_start),
      .cpu_addr  (cpu_addr),
      .cpu_we    (cpu_we),
      .cpu_wide  (cpu_wide),
      .shadow_en (shadow_en),
      .range_en  (range_en),
      .cpu_wait  (cpu_wait),
      .fast_we   (fast_we),
      .slow_we   (slow_we),
      .slow_re   (slow_re),
      .slow_addr (slow_addr)
   );

   task automatic check(input bit ok, input string req, input string what,
                        input longint act, input longint exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   function automatic int exp_stall(input int t0, input bit wide);
      int g = t0;
      while ((g % (2*S)) != S-1) g++;
      return g - t0 + S + (wide ? 2*S : 0);
   endfunction

   int          r_t0, r_stall, r_fast, r_sw, r_sr, r_vid;
   logic [23:0] r_a1, r_a2;
   logic        r_wait1;

   task automatic run_acc(input vec_t v, input int align, input bit intrude);
      int n = 0;
      shadow_en = v.shadow;
      range_en  = v.ren;
      @(negedge clk);
      while (!(tick && (align < 0 || (tno % (2*S)) == align))) @(negedge clk);
      cpu_addr  = v.addr;
      cpu_we    = v.we;
      cpu_wide  = v.wide;
      cyc_start = 1'b1;
      r_t0 = tno; r_stall = 0; r_sw = 0; r_sr = 0; r_vid = 0;
      r_a1 = '0; r_a2 = '0;
      @(negedge clk);
      cyc_start = 1'b0;
      r_wait1   = cpu_wait;
      r_fast    = int'(fast_we);
      for (int k = 0; k < 200; k++) begin
         @(negedge clk);
         cyc_start = tick && intrude && (tno == r_t0 + 2);
         if (cyc_start) begin
            cpu_addr = 24'h000500; cpu_we = 1'b1; cpu_wide = 1'b0;
         end
         if (fast_we) r_fast++;
         if (tick) begin
            if (!cpu_wait) break;
            r_stall++;
            if (slow_we || slow_re) begin
               if (slow_we) r_sw++; else r_sr++;
               if (((tno / S) % 2) == 0) r_vid++;
               if (n == 0) r_a1 = slow_addr;
               if (n == S) r_a2 = slow_addr;
               n++;
            end
         end
      end
      cyc_start = 1'b0;
   endtask

   task automatic judge(input vec_t v, input string req);
      bit   str  = (v.cls != 2'd0);
      int   bytes = v.wide ? 2 : 1;
      logic [23:0] ea1 = {7'h70, v.addr[16], v.addr[15:0]};
      logic [23:0] ea2 = {7'h70, v.addr[16], v.addr[15:0] + 16'd1};
      check(r_stall == (str ? exp_stall(r_t0, v.wide) : 0), req, "stall ticks",
            r_stall, str ? exp_stall(r_t0, v.wide) : 0);
      check(r_wait1 == str, req, "wait after start tick (R10)", r_wait1, str);
      check(r_fast == ((v.we && v.cls != 2'd1) ? 1 : 0), req, "fast_we pulses",
            r_fast, (v.we && v.cls != 2'd1) ? 1 : 0);
      check(r_sw == ((str && v.we) ? S*bytes : 0), req, "slow_we ticks",
            r_sw, (str && v.we) ? S*bytes : 0);
      check(r_sr == ((str && !v.we) ? S*bytes : 0), req, "slow_re ticks",
            r_sr, (str && !v.we) ? S*bytes : 0);
      check(r_vid == 0, req, "strobe in video slot", r_vid, 0);
      if (str) check(r_a1 == ea1, req, "first byte address", r_a1, ea1);
      if (str && v.wide) check(r_a2 == ea2, "R8", "second byte address", r_a2, ea2);
   endtask

   task automatic finish_tb;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_run++;
      n_fail++;
      $display("FAIL watchdog: run did not complete, actual hung expected done");
      finish_tb();
   end

   initial begin
      vec_t d;
      // R1: reset state
      repeat (4) @(negedge clk);
      check({cpu_wait, fast_we, slow_we, slow_re} == 4'b0, "R1", "outputs in reset",
            {cpu_wait, fast_we, slow_we, slow_re}, 0);
      rst = 1'b0;

      // Table walk
      for (int i = 0; i < NV; i++) begin
         repeat (VECS[i].gap) @(negedge clk);
         run_acc(VECS[i], -1, 1'b0);
         judge(VECS[i], $sformatf("R%0d", VECS[i].req));
      end

      // R10: start on the tick that ends a video slot, shortest stall
      d = '{24'hE00100, 1'b0, 1'b0, 1'b0, 2'b00, 2'd1, 3'd0, 4'd10};
      run_acc(d, S-1, 1'b0);
      check(r_stall == S, "R10", "aligned start stall", r_stall, S);
      judge(d, "R10");

      // R2: start on first tick of a CPU slot, that slot must be skipped
      d = '{24'hE10200, 1'b1, 1'b0, 1'b0, 2'b00, 2'd1, 3'd0, 4'd2};
      run_acc(d, S, 1'b0);
      check(r_stall == 3*S - 1, "R2", "worst start stall", r_stall, 3*S - 1);
      judge(d, "R2");

      // R9: a second request during a stall is ignored
      d = '{24'hE00300, 1'b1, 1'b0, 1'b1, 2'b11, 2'd1, 3'd0, 4'd9};
      run_acc(d, S, 1'b1);
      judge(d, "R9");

      // R1: reset in the middle of a stall, then phase restarts from zero
      shadow_en = 1'b0; range_en = 2'b00;
      @(negedge clk);
      while (!tick) @(negedge clk);
      cpu_addr = 24'hE00010; cpu_we = 1'b1; cpu_wide = 1'b1; cyc_start = 1'b1;
      @(negedge clk);
      cyc_start = 1'b0;
      repeat (4) @(negedge clk);
      rst = 1'b1;
      repeat (3) @(negedge clk);
      check({cpu_wait, fast_we, slow_we, slow_re} == 4'b0, "R1", "outputs after mid-stall reset",
            {cpu_wait, fast_we, slow_we, slow_re}, 0);
      rst = 1'b0;
      d = '{24'hE10400, 1'b0, 1'b0, 1'b0, 2'b00, 2'd1, 3'd0, 4'd1};
      run_acc(d, -1, 1'b0);
      judge(d, "R1");

      repeat (4) @(negedge clk);
      finish_tb();
   end

endmodule